// File: doc/BRIEF.md
# Trailing-Load Block Hold Table

This block sits beside the data cache of a core that runs two redundant copies of a program: a leading copy and a trailing copy that repeats the leading copy's work. When the leading copy loads from a cache block, the block must stay unchanged until the trailing copy has made the same load. Otherwise the two copies could read different values. The table records each such block address together with a count of trailing loads still to come. Before the cache replaces or invalidates a block, it asks the table. The table either allows the action at once or holds it back until the trailing copy catches up.

Leading loads arrive on a valid/ready stream. A load is accepted in any cycle where `lead_valid` and `lead_ready` are both high. The table lowers `lead_ready` when the load would need a new entry and none is free, or when the matching entry's counter is already at its maximum. The source must then hold the load steady until it is accepted. Trailing retirements arrive on a plain strobe and cannot be stalled. A replace or invalidate request gets its answer in the same cycle. After a deferred action becomes safe, the table signals this with a one-cycle release pulse that carries the block address.

Top module: `ldhold_table`

## Requirements
- R1: After reset the table holds no entries: `full` is 0, `lead_ready` is 1 and `release_valid` is 0.
- R2: An accepted leading load to an address that is not held creates an entry with a count of 1. A later replace request for that address is deferred.
- R3: An accepted leading load to an address that is already held adds 1 to that entry's count and creates no second entry. The block stays held until the same number of trailing retirements have been seen.
- R4: A trailing retirement for a held address subtracts 1 from the count. When the count reaches 0 and no deferral is pending, the entry is freed silently: no release pulse is raised, and a later request for the address is granted.
- R5: A replace request (`evict_valid`) for an address that is not held raises `evict_grant` in the same cycle and changes no state.
- R6: A replace request for a held address raises `evict_defer` in the same cycle and marks that entry as pending.
- R7: When a pending entry's count reaches 0, `release_valid` is 1 in the next cycle for exactly one cycle, with `release_addr` equal to the block address, and the entry is freed.
- R8: `full` is 1 exactly when every entry is in use. While the table is full, a load to a new address sees `lead_ready` at 0, but a load to a held address sees `lead_ready` at 1 unless R9 applies.
- R9: When the matching entry's count equals 2^CNT_W-1, `lead_ready` is 0 for that address, so the counter never wraps.
- R10: A trailing retirement for an address that is not held has no effect on any output or entry.
- R11: A leading load and a trailing retirement to the same held address in the same cycle leave its count unchanged, and no release is raised.
- R12: While `evict_valid` is 1, exactly one of `evict_grant` and `evict_defer` is 1. While it is 0, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_valid | input | 1 | Leading load offered |
| lead_ready | output | 1 | Leading load can be accepted this cycle |
| lead_addr | input | ADDR_W | Block address of the leading load |
| trail_valid | input | 1 | Trailing load retired this cycle |
| trail_addr | input | ADDR_W | Block address of the retired trailing load |
| evict_valid | input | 1 | Cache asks to replace or invalidate a block |
| evict_addr | input | ADDR_W | Block address of the request |
| evict_grant | output | 1 | Request may proceed now |
| evict_defer | output | 1 | Request is held until release |
| release_valid | output | 1 | A deferred action may now proceed |
| release_addr | output | ADDR_W | Block address of the release |
| full | output | 1 | No free entry is left |

## Verification
Several rules are checked by the assertions on every cycle. The request answer is always exactly one of grant or defer. Block addresses in the table never repeat. A release only ever follows a trailing retirement. A full table or a saturated counter always holds back `lead_ready`. Other behaviour can only be shown by the bench's scenarios. These cover matching loads and retirements over many cycles, deferral followed by a later release carrying the right address, silent freeing, retirements to unknown addresses, same-cycle collisions, and a long run of mixed traffic. In every one of them the bench's reference model predicts each output.

// File: rtl/ldhold_pkg.sv
`timescale 1ns/1ps
package ldhold_pkg;
  // Answer given to a cache replace/invalidate request in the current cycle.
  typedef enum logic [1:0] {
    EV_IDLE  = 2'b00,
    EV_GRANT = 2'b01,
    EV_DEFER = 2'b10
  } evict_resp_e;
endpackage

// File: rtl/ldhold_match.sv
`timescale 1ns/1ps
// Compares one key against every entry's stored address.
module ldhold_match #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 26
) (
  input  logic [ENTRIES-1:0]             valid_i,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0]              key_i,
  output logic [ENTRIES-1:0]             hit_o,
  output logic                           any_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_o[g] = valid_i[g] && (addr_i[g] == key_i);
  end
  assign any_o = |hit_o;
endmodule

// File: rtl/ldhold_alloc.sv
`timescale 1ns/1ps
// Picks the lowest-numbered free entry.
module ldhold_alloc #(
  parameter int ENTRIES = 16
) (
  input  logic [ENTRIES-1:0] valid_i,
  output logic [ENTRIES-1:0] pick_o,
  output logic               any_free_o
);
  logic [ENTRIES:0] seen;
  assign seen[0] = 1'b0;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_pick
    assign pick_o[g]  = !valid_i[g] && !seen[g];
    assign seen[g+1]  = seen[g] || !valid_i[g];
  end
  assign any_free_o = seen[ENTRIES];
endmodule

// File: rtl/ldhold_entry.sv
`timescale 1ns/1ps
// One tracked block: address, outstanding trailing-load count, pending flag.
module ldhold_entry #(
  parameter int ADDR_W = 26,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              inc_i,
  input  logic              dec_i,
  input  logic              pend_set_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              release_o
);
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nxt;
  logic              pend_q;
  logic              will_free;

  always_comb begin
    cnt_nxt = cnt_q;
    unique case ({inc_i, dec_i})
      2'b10:   cnt_nxt = cnt_q + CNT_W'(1);
      2'b01:   cnt_nxt = cnt_q - CNT_W'(1);
      default: cnt_nxt = cnt_q;
    endcase
  end

  assign will_free = valid_q && !alloc_i && (cnt_nxt == '0);
  // A request deferred in the very cycle the count empties still releases.
  assign release_o = will_free && (pend_q || pend_set_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      addr_q  <= addr_i;
      cnt_q   <= CNT_W'(1);
      pend_q  <= 1'b0;
    end else if (will_free) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else if (valid_q) begin
      cnt_q   <= cnt_nxt;
      pend_q  <= pend_q || pend_set_i;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/ldhold_table.sv
`timescale 1ns/1ps
module ldhold_table #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 26,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lead_valid,
  output logic              lead_ready,
  input  logic [ADDR_W-1:0] lead_addr,
  input  logic              trail_valid,
  input  logic [ADDR_W-1:0] trail_addr,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  output logic              evict_grant,
  output logic              evict_defer,
  output logic              release_valid,
  output logic [ADDR_W-1:0] release_addr,
  output logic              full
);
  import ldhold_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [ENTRIES-1:0]             ent_valid;
  logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr;
  logic [ENTRIES-1:0][CNT_W-1:0]  ent_cnt;
  logic [ENTRIES-1:0]             ent_rel;

  logic [ENTRIES-1:0] lead_hit, trail_hit, evict_hit;
  logic               lead_hit_any, trail_hit_any, evict_hit_any;
  logic [ENTRIES-1:0] free_pick;
  logic               any_free;
  logic [CNT_W-1:0]   hit_cnt;
  logic               lead_fire;
  logic [ADDR_W-1:0]  rel_addr_nxt;
  evict_resp_e        ev_resp;

  ldhold_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_lead_match (
    .valid_i(ent_valid), .addr_i(ent_addr), .key_i(lead_addr),
    .hit_o(lead_hit), .any_o(lead_hit_any));

  ldhold_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_trail_match (
    .valid_i(ent_valid), .addr_i(ent_addr), .key_i(trail_addr),
    .hit_o(trail_hit), .any_o(trail_hit_any));

  ldhold_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_evict_match (
    .valid_i(ent_valid), .addr_i(ent_addr), .key_i(evict_addr),
    .hit_o(evict_hit), .any_o(evict_hit_any));

  ldhold_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .valid_i(ent_valid), .pick_o(free_pick), .any_free_o(any_free));

  // Count of the entry the leading load matches (zero if none).
  always_comb begin
    hit_cnt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lead_hit[i]) hit_cnt = hit_cnt | ent_cnt[i];
    end
  end

  assign full       = !any_free;
  assign lead_ready = lead_hit_any ? (hit_cnt != CNT_MAX) : any_free;
  assign lead_fire  = lead_valid && lead_ready;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic alloc_g, inc_g, dec_g, pend_g;
    assign alloc_g = lead_fire && !lead_hit_any && free_pick[g];
    assign inc_g   = lead_fire && lead_hit[g];
    assign dec_g   = trail_valid && trail_hit[g];
    assign pend_g  = evict_valid && evict_hit[g];

    ldhold_entry #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .alloc_i(alloc_g), .inc_i(inc_g), .dec_i(dec_g), .pend_set_i(pend_g),
      .addr_i(lead_addr),
      .valid_o(ent_valid[g]), .addr_o(ent_addr[g]), .cnt_o(ent_cnt[g]),
      .release_o(ent_rel[g]));
  end

  always_comb begin
    if (!evict_valid)       ev_resp = EV_IDLE;
    else if (evict_hit_any) ev_resp = EV_DEFER;
    else                    ev_resp = EV_GRANT;
  end
  assign evict_grant = (ev_resp == EV_GRANT);
  assign evict_defer = (ev_resp == EV_DEFER);

  // Addresses are unique, so at most one entry releases per cycle.
  always_comb begin
    rel_addr_nxt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ent_rel[i]) rel_addr_nxt = rel_addr_nxt | ent_addr[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      release_valid <= 1'b0;
      release_addr  <= '0;
    end else begin
      release_valid <= |ent_rel;
      release_addr  <= rel_addr_nxt;
    end
  end

  // trail_hit_any is kept for the bound checker.
  logic unused_ok;
  assign unused_ok = trail_hit_any;
endmodule

// File: rtl/ldhold_checker.sv
`timescale 1ns/1ps
module ldhold_checker #(
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lead_valid,
  input logic               lead_ready,
  input logic               trail_valid,
  input logic               trail_hit_any,
  input logic               evict_valid,
  input logic               evict_grant,
  input logic               evict_defer,
  input logic               release_valid,
  input logic               full,
  input logic               lead_hit_any,
  input logic [ENTRIES-1:0] lead_hit,
  input logic [CNT_W-1:0]   hit_cnt
);
  a_r12_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> (evict_grant ^ evict_defer));

  a_r12_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !evict_valid |-> (!evict_grant && !evict_defer));

  a_r7_release_after_retire: assert property (@(posedge clk) disable iff (!rst_n)
    release_valid |-> ($past(trail_valid) && $past(trail_hit_any)));

  a_r7_single_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    (release_valid && !$past(trail_valid)) |-> 1'b0);

  a_r8_full_blocks_new: assert property (@(posedge clk) disable iff (!rst_n)
    (full && lead_valid && !lead_hit_any) |-> !lead_ready);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_hit_any && lead_ready) |-> (hit_cnt != {CNT_W{1'b1}}));

  a_r3_unique_address: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lead_hit));
endmodule

bind ldhold_table ldhold_checker #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_ldhold_chk (
  .clk(clk), .rst_n(rst_n),
  .lead_valid(lead_valid), .lead_ready(lead_ready),
  .trail_valid(trail_valid), .trail_hit_any(trail_hit_any),
  .evict_valid(evict_valid), .evict_grant(evict_grant), .evict_defer(evict_defer),
  .release_valid(release_valid), .full(full),
  .lead_hit_any(lead_hit_any), .lead_hit(lead_hit), .hit_cnt(hit_cnt));

// File: tb/ldhold_table_bench.sv
`timescale 1ns/1ps
module ldhold_table_bench;
  localparam int ENTRIES = 16;
  localparam int AW      = 26;
  localparam int CW      = 4;
  localparam int MAXC    = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lead_valid, trail_valid, evict_valid;
  logic [AW-1:0] lead_addr, trail_addr, evict_addr;
  logic          lead_ready, evict_grant, evict_defer, release_valid, full;
  logic [AW-1:0] release_addr;

  int  errors = 0;
  int  checks = 0;
  bit  done   = 0;

  // Reference model state
  int  mcnt  [logic [AW-1:0]];
  bit  mpend [logic [AW-1:0]];
  bit            exp_rel = 0;
  logic [AW-1:0] exp_rel_addr = '0;

  always #2.5ns clk = ~clk;

  ldhold_table #(.ENTRIES(ENTRIES), .ADDR_W(AW), .CNT_W(CW)) u_ldhold_table (
    .clk(clk), .rst_n(rst_n),
    .lead_valid(lead_valid), .lead_ready(lead_ready), .lead_addr(lead_addr),
    .trail_valid(trail_valid), .trail_addr(trail_addr),
    .evict_valid(evict_valid), .evict_addr(evict_addr),
    .evict_grant(evict_grant), .evict_defer(evict_defer),
    .release_valid(release_valid), .release_addr(release_addr),
    .full(full));

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, check, let the edge pass, update model.
  task automatic cyc(string tag, bit lv, logic [AW-1:0] la, bit tv, logic [AW-1:0] ta,
                     bit ev, logic [AW-1:0] ea);
    bit lh, e_ready, e_full, e_grant, e_defer, fire;
    lead_valid = lv;  lead_addr = la;
    trail_valid = tv; trail_addr = ta;
    evict_valid = ev; evict_addr = ea;
    #1;
    lh      = mcnt.exists(la);
    e_full  = (mcnt.num() == ENTRIES);
    e_ready = lh ? (mcnt[la] != MAXC) : !e_full;
    e_grant = ev && !mcnt.exists(ea);
    e_defer = ev && mcnt.exists(ea);
    chk(tag, "full(R8)", 64'(full), 64'(e_full));
    chk(tag, "lead_ready(R8/R9)", 64'(lead_ready), 64'(e_ready));
    chk(tag, "evict_grant(R5/R12)", 64'(evict_grant), 64'(e_grant));
    chk(tag, "evict_defer(R6/R12)", 64'(evict_defer), 64'(e_defer));
    chk(tag, "release_valid(R7)", 64'(release_valid), 64'(exp_rel));
    if (exp_rel) chk(tag, "release_addr(R7)", 64'(release_addr), 64'(exp_rel_addr));
    fire = lv && e_ready;
    @(posedge clk);
    exp_rel = 0;
    if (ev && mcnt.exists(ea)) mpend[ea] = 1;
    if (tv && mcnt.exists(ta)) mcnt[ta] = mcnt[ta] - 1;
    if (fire) begin
      if (mcnt.exists(la)) mcnt[la] = mcnt[la] + 1;
      else begin mcnt[la] = 1; mpend[la] = 0; end
    end
    if (tv && mcnt.exists(ta) && mcnt[ta] == 0) begin
      if (mpend[ta]) begin exp_rel = 1; exp_rel_addr = ta; end
      mcnt.delete(ta);
      mpend.delete(ta);
    end
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, '0, 0, '0, 0, '0);
  endtask

  localparam logic [AW-1:0] A = 26'h0001A0, B = 26'h0002B0, C = 26'h0003C0,
                            D = 26'h0004D0, E = 26'h0005E0, F = 26'h0006F0;

  initial begin
    rst_n = 0;
    lead_valid = 0; trail_valid = 0; evict_valid = 0;
    lead_addr = '0; trail_addr = '0; evict_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: empty after reset
    idle("R1");
    chk("R1", "full", 64'(full), 64'(0));
    chk("R1", "lead_ready", 64'(lead_ready), 64'(1));

    // R2: new address allocates; replace request is then deferred (R6)
    cyc("R2", 1, A, 0, '0, 0, '0);
    cyc("R6", 0, '0, 0, '0, 1, A);
    // R3: repeated loads count up
    cyc("R3", 1, A, 0, '0, 0, '0);
    cyc("R3", 1, A, 0, '0, 1, A);
    // R4/R7: three retirements, release appears the cycle after the last
    cyc("R4", 0, '0, 1, A, 0, '0);
    cyc("R4", 0, '0, 1, A, 1, A);
    cyc("R7", 0, '0, 1, A, 0, '0);
    idle("R7");
    chk("R7", "release_valid pulse", 64'(release_valid), 64'(0));
    cyc("R7", 0, '0, 0, '0, 1, A);

    // R5: absent address granted
    cyc("R5", 0, '0, 0, '0, 1, B);

    // R4: silent free without pending
    cyc("R4", 1, C, 0, '0, 0, '0);
    cyc("R4", 0, '0, 1, C, 0, '0);
    idle("R4");
    chk("R4", "no release on silent free", 64'(release_valid), 64'(0));
    cyc("R4", 0, '0, 0, '0, 1, C);

    // R10: retirement for unknown address ignored
    cyc("R10", 1, F, 0, '0, 0, '0);
    cyc("R10", 0, '0, 1, D, 0, '0);
    idle("R10");
    chk("R10", "release after unknown retire", 64'(release_valid), 64'(0));
    cyc("R10", 0, '0, 0, '0, 1, F);
    cyc("R10", 0, '0, 1, F, 0, '0);
    idle("R10");

    // R11: same-cycle load and retire on one address keep the count
    cyc("R11", 1, E, 0, '0, 0, '0);
    cyc("R11", 1, E, 1, E, 0, '0);
    cyc("R11", 0, '0, 0, '0, 1, E);
    cyc("R11", 0, '0, 1, E, 0, '0);
    idle("R11");

    // R9: saturate one counter
    for (int i = 0; i < MAXC + 1; i++) cyc("R9", 1, A, 0, '0, 0, '0);
    chk("R9", "ready low at max count", 64'(lead_ready), 64'(0));
    for (int i = 0; i < MAXC; i++) cyc("R9", 0, '0, 1, A, 0, '0);
    idle("R9");

    // R8: fill every entry
    for (int i = 0; i < ENTRIES; i++) cyc("R8", 1, AW'(26'h100 + i), 0, '0, 0, '0);
    cyc("R8", 1, AW'(26'h3FF), 0, '0, 0, '0);
    chk("R8", "ready low for new address", 64'(lead_ready), 64'(0));
    cyc("R8", 1, AW'(26'h105), 0, '0, 0, '0);
    cyc("R8", 0, '0, 1, AW'(26'h100), 0, '0);
    cyc("R8", 1, AW'(26'h3FF), 0, '0, 0, '0);
    for (int i = 1; i < ENTRIES; i++) cyc("R8", 0, '0, 1, AW'(26'h100 + i), 0, '0);
    cyc("R8", 0, '0, 1, AW'(26'h105), 0, '0);
    cyc("R8", 0, '0, 1, AW'(26'h3FF), 0, '0);
    idle("R8");

    // R12: mixed traffic over a small address pool
    for (int i = 0; i < 2000; i++) begin
      cyc("R12", 1'($urandom_range(0, 1)), AW'($urandom_range(0, 19)),
          1'($urandom_range(0, 1)), AW'($urandom_range(0, 19)),
          1'($urandom_range(0, 1)), AW'($urandom_range(0, 19)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule